// File: doc/BRIEF.md
# Repeat-Mode Synchronous Serial Master

This block is the master side of a clocked synchronous serial link. It sends 8-bit words on a data-out line and, in the same frame, collects 8 bits from a data-in line. It generates the serial clock itself. The host loads words into a two-slot transmit queue. The block sends them back to back for as long as a word is waiting when each frame's launch decision comes round.

After every frame the block raises a one-cycle completion interrupt. A reservation window of one serial-clock period follows. At the end of that window the block decides whether to start the next frame. If a word is queued, the next frame starts and the sequence continues. If nothing is queued, the sequence stops and the in-progress status drops.

Received words reach the receive buffer one frame late. A word moves there only when the following frame of the same sequence launches. So the last word of a sequence never reaches the receive buffer, and the host reads it from the shift register once the sequence is over.

The controller has four states:
- IDLE: the serial clock is high and no sequence is running.
- LOW: the low half of a bit.
- HIGH: the high half of a bit.
- GAP: the reservation window.

Transitions:
- IDLE to LOW: launch, when the queue holds a word.
- LOW to HIGH: sample, after HALF_DIV cycles.
- HIGH to LOW: next bit, after HALF_DIV cycles while bits remain.
- HIGH to GAP: frame end, after the 8th bit, which also raises the interrupt.
- GAP to LOW: chained launch, after 2*HALF_DIV cycles if a word is queued.
- GAP to IDLE: sequence end, after 2*HALF_DIV cycles if no word is queued.

Top module: `rpt_serial_master`

## Requirements
- R1: After reset the serial clock and data-out are high, status and interrupt are low, and both the receive buffer and the shift register read as zero.
- R2: A frame is 8 bits, MSB first. Data-out changes only when the serial clock falls, and data-in is sampled when it rises. Each clock half lasts HALF_DIV system clocks.
- R3: A transmit write while no sequence runs starts a sequence. The in-progress status rises on the launch edge, one clock after the write is sampled.
- R4: The transmit queue holds two words and sends them oldest first. A write while both slots are full replaces the newer word, and the replaced word is never sent.
- R5: Each completed frame raises the interrupt for exactly one clock, during the first cycle of the reservation window.
- R6: The launch decision falls 2*HALF_DIV clocks after the interrupt. A write sampled at least one clock before the decision edge chains another frame, and the status stays high throughout.
- R7: If the queue is empty at the decision, the sequence ends: the status falls and the serial clock stays high. A write sampled on or after the decision edge starts a new, unchained sequence.
- R8: On a chained launch, the shift register's received word moves into the receive buffer. Read select 0 returns the receive buffer.
- R9: The first launch of a sequence leaves the receive buffer unchanged. After a sequence ends, read select 1 returns the final received word from the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr_i | input | 1 | Transmit write strobe |
| tx_data_i | input | WORD_W | Word to queue for transmission |
| rd_sel_i | input | 1 | 0 selects the receive buffer, 1 the shift register |
| rd_data_o | output | WORD_W | Selected register contents |
| sck_o | output | 1 | Serial clock, idles high |
| so_o | output | 1 | Serial data out |
| si_i | input | 1 | Serial data in |
| irq_o | output | 1 | Frame-complete pulse |
| busy_o | output | 1 | Sequence in progress |

## Verification
The bench writes at the last clock that still falls inside the reservation window. It also writes exactly on the decision edge. A design with the window one cycle off would either drop a frame in the first case or chain an extra frame, with the receive buffer loaded, in the second. Four quick writes overflow the queue: a design that drops the oldest word, or that refuses the newest, sends the wrong words. After every sequence the bench reads both registers to confirm the one-frame lag. A design that copies the final word into the receive buffer at sequence end, or on an unchained launch, returns the wrong value there.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } rsm_state_e;
endpackage

// File: rtl/rsm_txq.sv
// Two-slot transmit queue; slot 0 is the oldest word.
module rsm_txq #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              pop_i,
    output logic              avail_o,
    output logic [WORD_W-1:0] head_o
);
    logic [WORD_W-1:0] s0_q, s1_q, s0_n, s1_n;
    logic              v0_q, v1_q, v0_n, v1_n;

    always_comb begin
        s0_n = s0_q;
        s1_n = s1_q;
        v0_n = v0_q;
        v1_n = v1_q;
        if (pop_i) begin
            s0_n = s1_q;
            v0_n = v1_q;
            v1_n = 1'b0;
        end
        if (push_i) begin
            if (!v0_n) begin
                s0_n = data_i;
                v0_n = 1'b1;
            end else begin
                // second slot, overwritten when already full
                s1_n = data_i;
                v1_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s0_q <= '0;
            s1_q <= '0;
            v0_q <= 1'b0;
            v1_q <= 1'b0;
        end else begin
            s0_q <= s0_n;
            s1_q <= s1_n;
            v0_q <= v0_n;
            v1_q <= v1_n;
        end
    end

    assign avail_o = v0_q;
    assign head_o  = s0_q;
endmodule

// File: rtl/rsm_timer.sv
// Phase counter for serial-clock halves and the reservation window.
module rsm_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_o <= '0;
        else if (clr_i) cnt_o <= '0;
        else            cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/rsm_shifter.sv
// Shift register, data-out bit, bit count and lagging receive buffer.
module rsm_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              chain_i,
    input  logic [WORD_W-1:0] load_data_i,
    input  logic              sample_i,
    input  logic              si_i,
    input  logic              fall_i,
    output logic              so_o,
    output logic [WORD_W-1:0] shift_o,
    output logic [WORD_W-1:0] rx_o,
    output logic              full_o
);
    localparam int BW = $clog2(WORD_W + 1);
    localparam logic [BW-1:0] BITS_END = BW'(WORD_W);

    logic [BW-1:0] bit_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_o   <= '0;
            rx_o      <= '0;
            so_o      <= 1'b1;
            bit_cnt_q <= '0;
        end else begin
            if (load_i) begin
                if (chain_i) rx_o <= shift_o;
                shift_o   <= load_data_i;
                so_o      <= load_data_i[WORD_W-1];
                bit_cnt_q <= '0;
            end else if (sample_i) begin
                shift_o   <= {shift_o[WORD_W-2:0], si_i};
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (fall_i) begin
                so_o <= shift_o[WORD_W-1];
            end
        end
    end

    assign full_o = (bit_cnt_q == BITS_END);
endmodule

// File: rtl/rpt_serial_master.sv
module rpt_serial_master
    import rsm_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_wr_i,
    input  logic [WORD_W-1:0] tx_data_i,
    input  logic              rd_sel_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              sck_o,
    output logic              so_o,
    input  logic              si_i,
    output logic              irq_o,
    output logic              busy_o
);
    localparam int TW = $clog2(2 * HALF_DIV + 1);
    localparam logic [TW-1:0] HALF_END = TW'(HALF_DIV - 1);
    localparam logic [TW-1:0] GAP_END  = TW'(2 * HALF_DIV - 1);

    rsm_state_e        state_q, state_n;
    logic [TW-1:0]     tmr_cnt;
    logic              tmr_clr, launch, sample, fall, end_frame, end_seq;
    logic              q_avail, frame_full;
    logic [WORD_W-1:0] q_head, shift_val, rx_buf_q;

    rsm_txq #(.WORD_W(WORD_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .push_i(tx_wr_i), .data_i(tx_data_i),
        .pop_i(launch), .avail_o(q_avail), .head_o(q_head)
    );

    rsm_timer #(.CNT_W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .cnt_o(tmr_cnt)
    );

    rsm_shifter #(.WORD_W(WORD_W)) u_shf (
        .clk(clk), .rst_n(rst_n), .load_i(launch), .chain_i(state_q == ST_GAP),
        .load_data_i(q_head), .sample_i(sample), .si_i(si_i), .fall_i(fall),
        .so_o(so_o), .shift_o(shift_val), .rx_o(rx_buf_q), .full_o(frame_full)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // transitions and strobes
    always_comb begin
        state_n   = state_q;
        tmr_clr   = 1'b0;
        launch    = 1'b0;
        sample    = 1'b0;
        fall      = 1'b0;
        end_frame = 1'b0;
        end_seq   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                tmr_clr = 1'b1;
                if (q_avail) begin
                    launch  = 1'b1;
                    state_n = ST_LOW;
                end
            end
            ST_LOW: begin
                if (tmr_cnt == HALF_END) begin
                    sample  = 1'b1;
                    tmr_clr = 1'b1;
                    state_n = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tmr_cnt == HALF_END) begin
                    tmr_clr = 1'b1;
                    if (frame_full) begin
                        end_frame = 1'b1;
                        state_n   = ST_GAP;
                    end else begin
                        fall    = 1'b1;
                        state_n = ST_LOW;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_cnt == GAP_END) begin
                    tmr_clr = 1'b1;
                    if (q_avail) begin
                        launch  = 1'b1;
                        state_n = ST_LOW;
                    end else begin
                        end_seq = 1'b1;
                        state_n = ST_IDLE;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_o  <= 1'b1;
            irq_o  <= 1'b0;
            busy_o <= 1'b0;
        end else begin
            irq_o <= end_frame;
            if (launch || fall) sck_o <= 1'b0;
            else if (sample)    sck_o <= 1'b1;
            if (launch)         busy_o <= 1'b1;
            else if (end_seq)   busy_o <= 1'b0;
        end
    end

    assign rd_data_o = rd_sel_i ? shift_val : rx_buf_q;
endmodule

// File: rtl/rsm_checker.sv
module rsm_checker #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sck_o,
    input logic              so_o,
    input logic              irq_o,
    input logic              busy_o,
    input logic [WORD_W-1:0] rx_buf
);
    // R2: data-out holds while the serial clock stays high
    a_r2_so_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(so_o));

    // R5: completion pulse lasts one clock
    a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R5: completion pulse only inside a sequence with the clock high
    a_r5_irq_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (busy_o && sck_o));

    // R7: no sequence means the serial clock idles high
    a_r7_idle_sck_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> sck_o);

    // R8: the receive buffer moves only on a launch edge within a sequence
    a_r8_rx_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_buf) |-> ($fell(sck_o) && busy_o));
endmodule

bind rpt_serial_master rsm_checker #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sck_o(sck_o), .so_o(so_o),
    .irq_o(irq_o), .busy_o(busy_o), .rx_buf(rx_buf_q)
);

// File: tb/rpt_serial_master_test.sv
module rpt_serial_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 2;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_wr = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic rd_sel = 1'b0;
    logic [W-1:0] rd_data;
    logic sck, so, irq, busy;
    logic si_drv = 1'b0;

    int n_chk = 0, n_bad = 0;
    logic [W-1:0] exp_q[$];
    int frame_idx = 0, bit_idx = 0, low_len = 0, busy_falls = 0, irq_cnt = 0;
    logic [W-1:0] got = '0, cur_slv = '0;
    logic sck_prev = 1'b1, busy_prev = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rpt_serial_master #(.WORD_W(W), .HALF_DIV(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
        .rd_sel_i(rd_sel), .rd_data_o(rd_data), .sck_o(sck), .so_o(so),
        .si_i(si_drv), .irq_o(irq), .busy_o(busy)
    );

    function automatic logic [W-1:0] slv_word(input int k);
        return 8'hA5 ^ 8'(k * 29);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // monitor: serial slave model and scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (sck_prev && !sck) begin
                if (bit_idx == 0) cur_slv = slv_word(frame_idx);
                si_drv = cur_slv[W-1-bit_idx];
            end
            if (!sck_prev && sck) begin
                check(low_len == HALF, "R2 low phase length", low_len, HALF);
                low_len = 0;
                got = {got[W-2:0], so};
                bit_idx++;
                if (bit_idx == W) begin
                    bit_idx = 0;
                    if (exp_q.size() == 0) check(1'b0, "R2 unexpected frame", got, 0);
                    else begin
                        logic [W-1:0] e;
                        e = exp_q.pop_front();
                        check(got == e, "R2 word on data-out", got, e);
                    end
                    frame_idx++;
                end
            end
            if (!sck) low_len++;
            if (irq) irq_cnt++;
            if (busy_prev && !busy) busy_falls++;
            sck_prev  = sck;
            busy_prev = busy;
        end
    end

    // driver
    task automatic push_word(input logic [W-1:0] w, input bit sent);
        if (sent) exp_q.push_back(w);
        tx_data = w;
        tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic wait_irq();
        do @(negedge clk); while (!irq);
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 4 * HALF + 4) begin
            @(negedge clk);
            if (!busy) q++; else q = 0;
        end
    endtask

    task automatic read_reg(input logic sel, output logic [W-1:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [W-1:0] v, rx_before;
        int f0, b0, i0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(sck == 1'b1, "R1 sck", sck, 1);
        check(so == 1'b1, "R1 so", so, 1);
        check(busy == 1'b0 && irq == 1'b0, "R1 busy/irq", {busy, irq}, 0);
        read_reg(1'b0, v); check(v == 0, "R1 rx buffer", v, 0);
        read_reg(1'b1, v); check(v == 0, "R1 shift register", v, 0);

        // R3, R9: single word sequence
        f0 = frame_idx; b0 = busy_falls; i0 = irq_cnt;
        push_word(8'h3C, 1'b1);
        @(negedge clk);
        check(busy == 1'b1, "R3 busy after launch", busy, 1);
        wait_quiet();
        check(frame_idx - f0 == 1, "R3 frame count", frame_idx - f0, 1);
        check(irq_cnt - i0 == 1, "R5 one pulse per frame", irq_cnt - i0, 1);
        read_reg(1'b1, v); check(v == slv_word(f0), "R9 last word in shift", v, slv_word(f0));
        read_reg(1'b0, v); check(v == 0, "R9 rx untouched", v, 0);

        // R8: two words queued at the start
        f0 = frame_idx; b0 = busy_falls; i0 = irq_cnt;
        push_word(8'h81, 1'b1);
        push_word(8'h7E, 1'b1);
        wait_quiet();
        check(frame_idx - f0 == 2, "R6 two-frame chain", frame_idx - f0, 2);
        check(busy_falls - b0 == 1, "R6 busy held across chain", busy_falls - b0, 1);
        check(irq_cnt - i0 == 2, "R5 pulses", irq_cnt - i0, 2);
        read_reg(1'b0, v); check(v == slv_word(f0), "R8 rx one behind", v, slv_word(f0));
        read_reg(1'b1, v); check(v == slv_word(f0 + 1), "R9 final in shift", v, slv_word(f0 + 1));

        // R4: overflow replaces newer word
        f0 = frame_idx;
        push_word(8'h11, 1'b1);
        push_word(8'h22, 1'b1);
        push_word(8'h33, 1'b0);
        push_word(8'h44, 1'b1);
        wait_quiet();
        check(frame_idx - f0 == 3, "R4 frames after overflow", frame_idx - f0, 3);
        check(exp_q.size() == 0, "R4 all expected words sent", exp_q.size(), 0);

        // R6: writes at the last cycle of each window
        f0 = frame_idx; b0 = busy_falls; i0 = irq_cnt;
        push_word(8'hC0, 1'b1);
        for (int k = 1; k < 5; k++) begin
            wait_irq();
            repeat (2 * HALF - 2) @(negedge clk);
            push_word(8'hC0 + 8'(k), 1'b1);
        end
        wait_quiet();
        check(frame_idx - f0 == 5, "R6 window chain frames", frame_idx - f0, 5);
        check(busy_falls - b0 == 1, "R6 busy held", busy_falls - b0, 1);
        check(irq_cnt - i0 == 5, "R5 pulses in chain", irq_cnt - i0, 5);
        read_reg(1'b0, v); check(v == slv_word(f0 + 3), "R8 rx lag in chain", v, slv_word(f0 + 3));
        read_reg(1'b1, v); check(v == slv_word(f0 + 4), "R9 shift after chain", v, slv_word(f0 + 4));

        // R7: write on the decision edge starts a fresh sequence
        read_reg(1'b0, rx_before);
        f0 = frame_idx; b0 = busy_falls;
        push_word(8'h5B, 1'b1);
        wait_irq();
        repeat (2 * HALF - 1) @(negedge clk);
        push_word(8'h6C, 1'b1);
        wait_quiet();
        check(frame_idx - f0 == 2, "R7 frames at boundary", frame_idx - f0, 2);
        check(busy_falls - b0 == 2, "R7 chain broken at decision", busy_falls - b0, 2);
        read_reg(1'b0, v); check(v == rx_before, "R7 rx not loaded on fresh start", v, rx_before);
        read_reg(1'b1, v); check(v == slv_word(f0 + 1), "R9 shift at boundary", v, slv_word(f0 + 1));

        // R7: write well after the sequence ended
        f0 = frame_idx;
        push_word(8'h0F, 1'b1);
        push_word(8'hF0, 1'b1);
        wait_irq();
        wait_irq();
        repeat (2 * HALF + 2) @(negedge clk);
        check(busy == 1'b0, "R7 ended after empty decision", busy, 0);
        check(sck == 1'b1, "R7 sck idle high", sck, 1);
        push_word(8'h99, 1'b1);
        wait_quiet();
        check(frame_idx - f0 == 3, "R7 late write frame", frame_idx - f0, 3);
        read_reg(1'b0, v); check(v == slv_word(f0), "R8 rx keeps chained word", v, slv_word(f0));
        read_reg(1'b1, v); check(v == slv_word(f0 + 2), "R9 shift after late", v, slv_word(f0 + 2));

        finish_run();
    end
endmodule